// File: doc/BRIEF.md
# Mode-Aware Serializer Lock Detector

This block decides when a multi-rate video serializer is locked. It then enables the serial output only when that decision holds. The block runs on the parallel word clock. It takes the PLL's own lock indication and qualifies it with a sync condition that depends on the selected operating mode:

- In SMPTE mode it hunts the incoming words for timing reference sequences.
- In DVB-ASI mode it hunts for K28.5 comma characters.
- In data-through mode it needs no sync at all.

A detected sync stays valid for a programmable number of word clocks after the last match. A loss of PLL lock, a change of mode or a change of bus width throws away all sync state at once.

The input bus carries two 10-bit symbol lanes. Lane 0 is bits 9:0 and lane 1 is bits 19:10. When the narrow select is high, only lane 0 is examined and a sequence is assembled from consecutive words. When it is low, both lanes are examined together on every word.

Top module: `vidlink_lock_det`

## Requirements
- R1: While reset is asserted (active low), and in the first cycle after it, `lock_out` and `ser_out_en` are 0.
- R2: `ser_out_en` always carries the same value as `lock_out`.
- R3: The clock edge that samples `pll_locked` low drives `lock_out` low and discards any detected sync. After PLL lock returns, SMPTE and DVB-ASI modes stay unlocked until a new match is found.
- R4: In SMPTE mode (`op_mode` = 0) with `narrow_bus` = 1, a lane-0 sequence over three consecutive words 3FF, 000, 000 is a match. The edge that samples the third word sets `lock_out` if the PLL is locked. A partial sequence does not set it.
- R5: In SMPTE mode with `narrow_bus` = 0, every word of the 3FF, 000, 000 sequence must show the value in both lanes. A sequence seen on only one lane is not a match.
- R6: In DVB-ASI mode (`op_mode` = 1), a word whose lane 0 holds 0FA or 305 is a match. With `narrow_bus` = 0, the same check also applies to lane 1. Lane 1 is ignored when `narrow_bus` = 1. The edge that samples the matching word sets `lock_out`.
- R7: Comma words do not count as a match in SMPTE mode. Timing reference sequences do not count as a match in DVB-ASI mode.
- R8: In data-through mode (`op_mode` = 2), `lock_out` follows `pll_locked` one edge later, whatever the word contents.
- R9: After the edge of the last match, the sync stays valid for WATCH_LEN edges. If no new match arrives, the WATCH_LEN-th edge clears it and `lock_out` falls. Any new match restarts the window.
- R10: An edge that sees `op_mode` or `narrow_bus` differ from its value at the previous edge drives `lock_out` low. That edge also clears any detected sync and any partly received sequence.
- R11: `op_mode` = 3 is reserved and never asserts `lock_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_word | input | 1 | Parallel word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pll_locked | input | 1 | Lock indication from the serializer PLL |
| op_mode | input | 2 | 0 SMPTE, 1 DVB-ASI, 2 data-through, 3 reserved |
| narrow_bus | input | 1 | 1: only lane 0 carries data; 0: both lanes carry data |
| word_in | input | 20 | Parallel word; lane 0 in bits 9:0, lane 1 in bits 19:10 |
| lock_out | output | 1 | Registered lock status |
| ser_out_en | output | 1 | Serial output enable, equal to the lock status |

## Verification
The bench drives the following corner cases:

- **Watchdog boundary.** It checks the edge just before expiry and the expiry edge itself, both with and without a refreshing match. A counter that is off by one shows up as lock lasting one edge too long or too short.
- **Stale partial sequence.** It sends a partial timing reference sequence followed by a width change. A design that keeps the partial history would lock on the leftover words.
- **Lane rules.** It sends sequences on a single lane in wide mode, and commas on lane 1 in narrow mode. A design that ORs or mis-masks the lanes would lock on these.
- **Lock loss and recovery.** It drops the PLL, sends patterns of the wrong mode, and selects the reserved mode. A design that remembers sync across a PLL drop would relock with no new match.

// File: rtl/serlock_pkg.sv
package serlock_pkg;

  localparam int SYM_W = 10;

  typedef enum logic [1:0] {
    MODE_SMPTE = 2'd0,
    MODE_ASI   = 2'd1,
    MODE_THRU  = 2'd2,
    MODE_RSVD  = 2'd3
  } op_mode_e;

  typedef enum logic [1:0] {
    SYM_OTHER = 2'd0,
    SYM_ONES  = 2'd1,
    SYM_ZEROS = 2'd2
  } sym_kind_e;

  // Classify one symbol against the two TRS preamble values.
  function automatic sym_kind_e sym_kind(input logic [SYM_W-1:0] s);
    if (s == {SYM_W{1'b1}}) return SYM_ONES;
    if (s == {SYM_W{1'b0}}) return SYM_ZEROS;
    return SYM_OTHER;
  endfunction

  // Either running-disparity form of the comma character.
  function automatic logic is_comma(input logic [SYM_W-1:0] s);
    return (s == 10'b0011111010) || (s == 10'b1100000101);
  endfunction

  // True for the lane that must be examined under the current width.
  function automatic logic lane_active(input int lane, input logic narrow);
    return (lane == 0) || !narrow;
  endfunction

endpackage

// File: rtl/trs_hunt.sv
module trs_hunt
  import serlock_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   narrow,
  input  logic [LANES*SYM_W-1:0] word,
  output logic                   hit
);

  logic [LANES-1:0] lane_ones;
  logic [LANES-1:0] lane_zeros;
  sym_kind_e        word_kind;
  sym_kind_e        h1_q;
  sym_kind_e        h2_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_ones[g]  = (sym_kind(word[g*SYM_W +: SYM_W]) == SYM_ONES)
                           || !lane_active(g, narrow);
    assign lane_zeros[g] = (sym_kind(word[g*SYM_W +: SYM_W]) == SYM_ZEROS)
                           || !lane_active(g, narrow);
  end

  always_comb begin
    if (&lane_ones)       word_kind = SYM_ONES;
    else if (&lane_zeros) word_kind = SYM_ZEROS;
    else                  word_kind = SYM_OTHER;
  end

  assign hit = (h2_q == SYM_ONES) && (h1_q == SYM_ZEROS) && (word_kind == SYM_ZEROS);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      h1_q <= SYM_OTHER;
      h2_q <= SYM_OTHER;
    end else begin
      h2_q <= h1_q;
      h1_q <= word_kind;
    end
  end

endmodule

// File: rtl/comma_hunt.sv
module comma_hunt
  import serlock_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                   narrow,
  input  logic [LANES*SYM_W-1:0] word,
  output logic                   hit
);

  logic [LANES-1:0] lane_hit;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_hit[g] = is_comma(word[g*SYM_W +: SYM_W]) && lane_active(g, narrow);
  end

  assign hit = |lane_hit;

endmodule

// File: rtl/sync_watchdog.sv
module sync_watchdog #(
  parameter int WATCH_LEN = 2200,
  parameter int CW        = $clog2(WATCH_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kill,
  input  logic          hit,
  output logic          sync_d,
  output logic          sync_q,
  output logic [CW-1:0] cnt_q
);

  localparam logic [CW-1:0] LAST = CW'(WATCH_LEN - 1);

  logic          expire;
  logic [CW-1:0] cnt_d;

  assign expire = sync_q && !kill && !hit && (cnt_q == LAST);

  always_comb begin
    if (kill)        sync_d = 1'b0;
    else if (hit)    sync_d = 1'b1;
    else if (expire) sync_d = 1'b0;
    else             sync_d = sync_q;
  end

  always_comb begin
    if (kill || hit || !sync_d) cnt_d = '0;
    else                        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sync_q <= sync_d;
      cnt_q  <= cnt_d;
    end
  end

endmodule

// File: rtl/vidlink_lock_det.sv
module vidlink_lock_det
  import serlock_pkg::*;
#(
  parameter int LANES     = 2,
  parameter int WATCH_LEN = 2200,
  parameter int BUS_W     = LANES * SYM_W,
  parameter int CW        = $clog2(WATCH_LEN + 1)
) (
  input  logic             clk_word,
  input  logic             rst_n,
  input  logic             pll_locked,
  input  logic [1:0]       op_mode,
  input  logic             narrow_bus,
  input  logic [BUS_W-1:0] word_in,
  output logic             lock_out,
  output logic             ser_out_en
);

  op_mode_e      mode_now;
  op_mode_e      mode_q;
  logic          narrow_q;
  logic          cfg_change;
  logic          kill;
  logic          trs_hit;
  logic          comma_hit;
  logic          sync_hit;
  logic          sync_d;
  logic          sync_q;
  logic [CW-1:0] wd_cnt;
  logic          lock_d;
  logic          lock_q;

  assign mode_now   = op_mode_e'(op_mode);
  assign cfg_change = (mode_now != mode_q) || (narrow_bus != narrow_q);
  assign kill       = cfg_change || !pll_locked;

  trs_hunt #(.LANES(LANES)) u_trs (
    .clk    (clk_word),
    .rst_n  (rst_n),
    .clr    (kill),
    .narrow (narrow_bus),
    .word   (word_in),
    .hit    (trs_hit)
  );

  comma_hunt #(.LANES(LANES)) u_comma (
    .narrow (narrow_bus),
    .word   (word_in),
    .hit    (comma_hit)
  );

  always_comb begin
    unique case (mode_now)
      MODE_SMPTE: sync_hit = trs_hit;
      MODE_ASI:   sync_hit = comma_hit;
      default:    sync_hit = 1'b0;
    endcase
  end

  sync_watchdog #(.WATCH_LEN(WATCH_LEN), .CW(CW)) u_wd (
    .clk    (clk_word),
    .rst_n  (rst_n),
    .kill   (kill),
    .hit    (sync_hit),
    .sync_d (sync_d),
    .sync_q (sync_q),
    .cnt_q  (wd_cnt)
  );

  always_comb begin
    unique case (mode_now)
      MODE_SMPTE, MODE_ASI: lock_d = !kill && sync_d;
      MODE_THRU:            lock_d = !kill;
      default:              lock_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_word) begin
    if (!rst_n) begin
      mode_q   <= MODE_SMPTE;
      narrow_q <= 1'b0;
      lock_q   <= 1'b0;
    end else begin
      mode_q   <= mode_now;
      narrow_q <= narrow_bus;
      lock_q   <= lock_d;
    end
  end

  assign lock_out   = lock_q;
  assign ser_out_en = lock_q;

endmodule

// File: rtl/serlock_chk.sv
module serlock_chk #(
  parameter int WATCH_LEN = 2200,
  parameter int CW        = $clog2(WATCH_LEN + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pll_locked,
  input logic [1:0]    op_mode,
  input logic          lock_out,
  input logic          cfg_change,
  input logic          sync_hit,
  input logic          sync_q,
  input logic [CW-1:0] wd_cnt
);

  // R3
  pll_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_locked |=> (!lock_out && !sync_q));

  // R10
  cfg_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_change |=> (!lock_out && !sync_q));

  // R11
  rsvd_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode == 2'd3) |=> !lock_out);

  // R8
  thru_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode == 2'd2 && pll_locked && !cfg_change) |=> lock_out);

  // R4
  sync_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_q) |-> $past(sync_hit));

  // R9
  wd_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_cnt < CW'(WATCH_LEN));

endmodule

bind vidlink_lock_det serlock_chk #(.WATCH_LEN(WATCH_LEN), .CW(CW)) u_chk (
  .clk        (clk_word),
  .rst_n      (rst_n),
  .pll_locked (pll_locked),
  .op_mode    (op_mode),
  .lock_out   (lock_out),
  .cfg_change (cfg_change),
  .sync_hit   (sync_hit),
  .sync_q     (sync_q),
  .wd_cnt     (wd_cnt)
);

// File: tb/test_vidlink_lock_det.sv
module test_vidlink_lock_det;

  localparam int WL = 40;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pll_locked;
  logic [1:0]  op_mode;
  logic        narrow_bus;
  logic [19:0] word_in;
  logic        lock_out;
  logic        ser_out_en;

  int    total = 0;
  int    bad   = 0;
  string cur_req = "R1";
  bit    done = 0;

  always #10 clk = ~clk;

  vidlink_lock_det #(.WATCH_LEN(WL)) i_vidlink_lock_det (
    .clk_word   (clk),
    .rst_n      (rst_n),
    .pll_locked (pll_locked),
    .op_mode    (op_mode),
    .narrow_bus (narrow_bus),
    .word_in    (word_in),
    .lock_out   (lock_out),
    .ser_out_en (ser_out_en)
  );

  // Behavioural reference
  logic [19:0] seen[$];
  bit          m_sync;
  int          m_since;
  logic [1:0]  m_pmode;
  bit          m_pnar;
  bit          m_lock;

  function automatic bit lanes_eq(logic [19:0] w, logic [9:0] v, bit nar);
    if (nar) return w[9:0] == v;
    return (w[9:0] == v) && (w[19:10] == v);
  endfunction

  function automatic bit k28(logic [9:0] s);
    return s == 10'h0FA || s == 10'h305;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      seen.delete();
      m_sync = 0; m_since = 0; m_pmode = 2'd0; m_pnar = 0; m_lock = 0;
    end else begin
      bit drop, found;
      drop  = !pll_locked || (op_mode != m_pmode) || (narrow_bus != m_pnar);
      found = 0;
      if (op_mode == 2'd0)
        found = seen.size() == 2 && lanes_eq(seen[0], 10'h3FF, narrow_bus)
                && lanes_eq(seen[1], 10'h000, narrow_bus)
                && lanes_eq(word_in, 10'h000, narrow_bus);
      else if (op_mode == 2'd1)
        found = k28(word_in[9:0]) || (!narrow_bus && k28(word_in[19:10]));
      if (drop) begin
        m_sync = 0; m_since = 0; seen.delete();
      end else begin
        if (found) begin
          m_sync = 1; m_since = 0;
        end else if (m_sync) begin
          m_since++;
          if (m_since == WL) begin m_sync = 0; m_since = 0; end
        end
        seen.push_back(word_in);
        if (seen.size() > 2) void'(seen.pop_front());
      end
      m_lock = !drop && (op_mode == 2'd2 || (op_mode < 2'd2 && m_sync));
      m_pmode = op_mode;
      m_pnar  = narrow_bus;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      total++;
      if (lock_out !== m_lock || ser_out_en !== m_lock) begin
        bad++;
        $display("FAIL %s model: lock_out=%b ser_out_en=%b expected=%b",
                 cur_req, lock_out, ser_out_en, m_lock);
      end
    end
  end

  task automatic chk(input string r, input bit exp);
    total++;
    if (lock_out !== exp || ser_out_en !== exp) begin
      bad++;
      $display("FAIL %s: lock_out=%b ser_out_en=%b expected=%b",
               r, lock_out, ser_out_en, exp);
    end
  endtask

  task automatic put(input logic [19:0] w);
    word_in = w;
    @(negedge clk);
  endtask

  task automatic fill(input int n, input logic [19:0] w);
    for (int i = 0; i < n; i++) put(w);
  endtask

  task automatic trs(input bit wide);
    put(wide ? 20'hFFFFF : 20'h803FF);
    put(wide ? 20'h00000 : 20'h80000);
    put(wide ? 20'h00000 : 20'h80000);
  endtask

  localparam logic [19:0] FILL = 20'h80200;

  initial begin
    rst_n = 0; pll_locked = 0; op_mode = 2'd0; narrow_bus = 0; word_in = '0;
    repeat (3) @(negedge clk);
    chk("R1", 0);
    rst_n = 1;
    put(FILL);
    chk("R1", 0);

    cur_req = "R8";
    pll_locked = 1; op_mode = 2'd2;
    put(FILL); chk("R10", 0);
    put(FILL); chk("R8", 1); chk("R2", 1);
    cur_req = "R3";
    pll_locked = 0; put(FILL); chk("R3", 0);
    pll_locked = 1; put(FILL); chk("R8", 1);

    cur_req = "R4";
    op_mode = 2'd0; narrow_bus = 1;
    put(FILL); chk("R10", 0);
    put(20'h803FF); put(20'h80000); chk("R4", 0);
    put(20'h80000); chk("R4", 1);

    cur_req = "R9";
    fill(WL - 1, FILL); chk("R9", 1);
    put(FILL); chk("R9", 0);
    trs(0); chk("R4", 1);
    fill(30, FILL); trs(0);
    fill(WL - 1, FILL); chk("R9", 1);
    put(FILL); chk("R9", 0);

    cur_req = "R7";
    put(20'h800FA); put(20'h80305); chk("R7", 0);

    cur_req = "R10";
    put(20'h803FF); put(20'h80000);
    narrow_bus = 0; put(20'h00000); chk("R10", 0);
    put(20'h00000); chk("R10", 0);

    cur_req = "R5";
    trs(1); chk("R5", 1);
    fill(WL, 20'h80200); chk("R9", 0);
    put(20'h803FF); put(20'h80000); put(20'h80000); chk("R5", 0);

    cur_req = "R6";
    op_mode = 2'd1;
    put(FILL); chk("R10", 0);
    put({10'h0FA, 10'h200}); chk("R6", 1);
    fill(WL, FILL); chk("R9", 0);
    trs(1); chk("R7", 0);
    narrow_bus = 1; put(FILL); chk("R10", 0);
    put({10'h200, 10'h305}); chk("R6", 1);
    cur_req = "R3";
    pll_locked = 0; put(FILL); chk("R3", 0);
    pll_locked = 1; put(FILL); chk("R3", 0);
    cur_req = "R6";
    put({10'h0FA, 10'h200}); chk("R6", 0);

    cur_req = "R11";
    op_mode = 2'd3; put(FILL);
    put(20'h800FA); trs(0); chk("R11", 0);
    fill(3, FILL); chk("R11", 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule